// File: doc/BRIEF.md
# ALU Right-Operand Decoder

This block sits in the decode stage of a 32-bit core. It takes one ALU-class instruction word, together with the word that follows it in the instruction stream, and works out three things. The first is the destination register index. The second is the first source register index and what kind of register it names. The third is the fully extended 32-bit right-hand operand. It also says whether the following word was used as an immediate, so that fetch can step over that word.

Four addressing modes are decoded:

- Mode 0: a zero-filled 16-bit immediate.
- Mode 1: a 16-bit immediate forced negative.
- Mode 2: a separate source register with a signed 12-bit immediate.
- Mode 3: a separate source register with a signed 8-bit immediate that is then narrowed and re-extended by a 3-bit operand type. In this mode one escape immediate value replaces the 8-bit immediate with the following 32-bit word.

Anything the decoder cannot place raises an illegal flag with a zero operand. All outputs are registered, so results appear one clock after the instruction is presented.

Top module: `alu_opnd_gen`

## Requirements
- R1: While rst_ni is low, and immediately when it falls, every output is zero.
- R2: Outputs are registered. The values seen after a rising clock edge reflect the inputs sampled at that edge, and they do not change between edges.
- R3: Bits 31:30 equal to 01 mark an ALU instruction. Bits 23:20 are the mode and bits 19:16 are the destination. The first source index is the destination in modes 0 and 1, and bits 15:12 in every other mode.
- R4: In mode 0 the operand is bits 15:0 zero-filled to 32 bits.
- R5: In mode 1 the operand is bits 15:0 ORed with 0xFFFF0000, so its upper half is all ones.
- R6: In mode 2 the operand is bits 11:0 sign-extended to 32 bits.
- R7: In mode 3 the 8-bit immediate is {bits 11:8, bits 3:0}, sign-extended to 32 bits. The type field in bits 7:5 then picks the operand: 0 = low byte signed, 1 = low byte zero-filled, 2 = low half signed, 3 = low half zero-filled, 4 = full word.
- R8: In mode 3, the immediate value 0x80 makes the following word the source for the type step of R7, and take_next_o is 1. take_next_o is 0 in every other case.
- R9: In mode 3, bit 4 set remaps the first source. Index 0 gives kind 1 (condition codes), index 1 gives kind 2 (link register), and indices 13 to 15 give kind 0 (general register) with the same index. Kind is 0 whenever bit 4 is clear or the mode is not 3.
- R10: The instruction is illegal when bits 31:30 are not 01, when the mode is 4 to 15, when the mode 3 type is 5 to 7, or when bit 4 is set in mode 3 with a source index of 2 to 12. An illegal instruction gives illegal_o = 1, a zero operand, take_next_o = 0 and kind 0. The destination and source indices are still decoded as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_i | input | 32 | Instruction word |
| next_word_i | input | 32 | Word following the instruction |
| dst_idx_o | output | 4 | Destination register index |
| src1_idx_o | output | 4 | First source register index |
| src1_kind_o | output | 2 | 0 general register, 1 condition codes, 2 link register |
| rhs_o | output | 32 | Extended right-hand operand |
| take_next_o | output | 1 | Following word consumed as immediate |
| illegal_o | output | 1 | Instruction not decodable |

## Verification
Some rules are checked on every cycle. An illegal result always carries a zero operand and no consumed word. A special register kind only ever appears with index 0 or 1. Modes 0 and 1 reuse the destination as the source. Mode 1 always yields an operand with its upper half all ones. When the following word is consumed with the full-word type, it passes through unchanged. The exact result of each type extension, the escape interplay with narrow types, the rejected register indices and the reset and latency timing are shown only by the bench scenarios.

// File: rtl/alu_opnd_pkg.sv
package alu_opnd_pkg;
  localparam int unsigned INST_W = 32;
  localparam int unsigned IDX_W  = 4;

  localparam logic [1:0] KIND_GPR  = 2'd0;
  localparam logic [1:0] KIND_CC   = 2'd1;
  localparam logic [1:0] KIND_LINK = 2'd2;

  localparam logic [2:0] TY_SBYTE = 3'd0;
  localparam logic [2:0] TY_UBYTE = 3'd1;
  localparam logic [2:0] TY_SHALF = 3'd2;
  localparam logic [2:0] TY_UHALF = 3'd3;
  localparam logic [2:0] TY_WORD  = 3'd4;

  localparam logic [7:0] IMM8_ESC = 8'h80;

  typedef struct packed {
    logic             is_alu;
    logic [3:0]       mode;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] src_fld;
    logic [2:0]       ty;
    logic             xreg;
    logic [7:0]       imm8;
    logic [15:0]      imm16;
    logic [11:0]      imm12;
  } inst_fields_t;
endpackage

// File: rtl/opnd_field_dec.sv
module opnd_field_dec
  import alu_opnd_pkg::*;
(
  input  logic [INST_W-1:0] inst_i,
  output inst_fields_t      fld_o
);
  always_comb begin
    fld_o.is_alu  = (inst_i[31:30] == 2'b01);
    fld_o.mode    = inst_i[23:20];
    fld_o.dst     = inst_i[19:16];
    fld_o.src_fld = inst_i[15:12];
    fld_o.ty      = inst_i[7:5];
    fld_o.xreg    = inst_i[4];
    fld_o.imm8    = {inst_i[11:8], inst_i[3:0]};
    fld_o.imm16   = inst_i[15:0];
    fld_o.imm12   = inst_i[11:0];
  end
endmodule

// File: rtl/opnd_type_ext.sv
module opnd_type_ext
  import alu_opnd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [2:0]        ty_i,
  output logic [DATA_W-1:0] val_o,
  output logic              bad_ty_o
);
  localparam int unsigned BYTE_PAD = DATA_W - 8;
  localparam int unsigned HALF_PAD = DATA_W - 16;

  always_comb begin
    bad_ty_o = 1'b0;
    unique case (ty_i)
      TY_SBYTE: val_o = {{BYTE_PAD{raw_i[7]}}, raw_i[7:0]};
      TY_UBYTE: val_o = {{BYTE_PAD{1'b0}}, raw_i[7:0]};
      TY_SHALF: val_o = {{HALF_PAD{raw_i[15]}}, raw_i[15:0]};
      TY_UHALF: val_o = {{HALF_PAD{1'b0}}, raw_i[15:0]};
      TY_WORD:  val_o = raw_i;
      default: begin
        val_o    = '0;
        bad_ty_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opnd_src_map.sv
module opnd_src_map
  import alu_opnd_pkg::*;
(
  input  logic             xreg_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [1:0]       kind_o,
  output logic             resv_o
);
  localparam logic [IDX_W-1:0] FIRST_GPR = 4'd13;

  always_comb begin
    kind_o = KIND_GPR;
    resv_o = 1'b0;
    if (xreg_i) begin
      if (idx_i == 4'd0)            kind_o = KIND_CC;
      else if (idx_i == 4'd1)       kind_o = KIND_LINK;
      else if (idx_i < FIRST_GPR)   resv_o = 1'b1;
    end
  end
endmodule

// File: rtl/alu_opnd_gen.sv
module alu_opnd_gen
  import alu_opnd_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       inst_i,
  input  logic [DATA_W-1:0] next_word_i,
  output logic [3:0]        dst_idx_o,
  output logic [3:0]        src1_idx_o,
  output logic [1:0]        src1_kind_o,
  output logic [DATA_W-1:0] rhs_o,
  output logic              take_next_o,
  output logic              illegal_o
);
  localparam int unsigned PAD8  = DATA_W - 8;
  localparam int unsigned PAD12 = DATA_W - 12;
  localparam int unsigned PAD16 = DATA_W - 16;

  inst_fields_t      fld;
  logic              mode3, esc;
  logic [DATA_W-1:0] ty_raw, ty_val, rhs_n;
  logic              bad_ty, resv, ill_n;
  logic [1:0]        kind_raw;
  logic [IDX_W-1:0]  src1_n;

  opnd_field_dec u_dec (.inst_i(inst_i), .fld_o(fld));

  assign mode3  = (fld.mode == 4'd3);
  assign esc    = mode3 && (fld.imm8 == IMM8_ESC);
  assign ty_raw = esc ? next_word_i : {{PAD8{fld.imm8[7]}}, fld.imm8};

  opnd_type_ext #(.DATA_W(DATA_W)) u_ext (
    .raw_i(ty_raw), .ty_i(fld.ty), .val_o(ty_val), .bad_ty_o(bad_ty)
  );

  opnd_src_map u_map (
    .xreg_i(mode3 && fld.xreg), .idx_i(fld.src_fld),
    .kind_o(kind_raw), .resv_o(resv)
  );

  assign src1_n = (fld.mode < 4'd2) ? fld.dst : fld.src_fld;
  assign ill_n  = !fld.is_alu || (fld.mode > 4'd3) || (mode3 && (bad_ty || resv));

  always_comb begin
    unique case (fld.mode)
      4'd0:    rhs_n = {{PAD16{1'b0}}, fld.imm16};
      4'd1:    rhs_n = {{PAD16{1'b1}}, fld.imm16};
      4'd2:    rhs_n = {{PAD12{fld.imm12[11]}}, fld.imm12};
      4'd3:    rhs_n = ty_val;
      default: rhs_n = '0;
    endcase
    if (ill_n) rhs_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_idx_o   <= '0;
      src1_idx_o  <= '0;
      src1_kind_o <= KIND_GPR;
      rhs_o       <= '0;
      take_next_o <= 1'b0;
      illegal_o   <= 1'b0;
    end else begin
      dst_idx_o   <= fld.dst;
      src1_idx_o  <= src1_n;
      src1_kind_o <= ill_n ? KIND_GPR : kind_raw;
      rhs_o       <= rhs_n;
      take_next_o <= esc && !ill_n;
      illegal_o   <= ill_n;
    end
  end
endmodule

// File: rtl/alu_opnd_gen_chk.sv
module alu_opnd_gen_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       inst_i,
  input logic [DATA_W-1:0] next_word_i,
  input logic [3:0]        dst_idx_o,
  input logic [3:0]        src1_idx_o,
  input logic [1:0]        src1_kind_o,
  input logic [DATA_W-1:0] rhs_o,
  input logic              take_next_o,
  input logic              illegal_o
);
  logic seen_clk;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_clk <= 1'b0;
    else         seen_clk <= 1'b1;
  end

  p_illegal_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (rhs_o == '0 && !take_next_o && src1_kind_o == 2'd0));

  p_kind_index_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src1_kind_o != 2'd0) |-> (src1_idx_o <= 4'd1 && !illegal_o));

  p_mode1_negative_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_clk && $past(inst_i[31:30] == 2'b01 && inst_i[23:20] == 4'd1))
      |-> (rhs_o[DATA_W-1:16] == '1));

  p_src_is_dst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_clk && $past(inst_i[23:20] <= 4'd1)) |-> (src1_idx_o == dst_idx_o));

  p_escape_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_clk && take_next_o && $past(inst_i[7:5]) == 3'd4) |-> (rhs_o == $past(next_word_i)));
endmodule

bind alu_opnd_gen alu_opnd_gen_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_alu_opnd_gen.sv
module test_alu_opnd_gen;
  localparam int N = 21;

  localparam logic [31:0] V_INST [N] = '{
    32'h42038001, 32'h42151234, 32'h42279800, 32'h4220A7FF, 32'h42312F00,
    32'h42312F20, 32'h42312F60, 32'h4231278F, 32'h42312045, 32'h42302880,
    32'h42302840, 32'h42302820, 32'h42300091, 32'h42301091, 32'h4230F091,
    32'h42305091, 32'h42431234, 32'h42F00000, 32'h423010A3, 32'h82030001,
    32'h423008C0};
  localparam logic [31:0] V_NEXT [N] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'hDEADBEEF, 32'h12348001, 32'hCAFEBABE,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h55555555};
  localparam logic [31:0] V_RHS [N] = '{
    32'h00008001, 32'hFFFF1234, 32'hFFFFF800, 32'h000007FF, 32'hFFFFFFF0,
    32'h000000F0, 32'h0000FFF0, 32'h0000007F, 32'h00000005, 32'hDEADBEEF,
    32'hFFFF8001, 32'h000000BE, 32'h00000001, 32'h00000001, 32'h00000001,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [3:0] V_DST [N] = '{
    4'h3, 4'h5, 4'h7, 4'h0, 4'h1, 4'h1, 4'h1, 4'h1, 4'h1, 4'h0, 4'h0,
    4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h3, 4'h0, 4'h0, 4'h3, 4'h0};
  localparam logic [3:0] V_SRC [N] = '{
    4'h3, 4'h5, 4'h9, 4'hA, 4'h2, 4'h2, 4'h2, 4'h2, 4'h2, 4'h2, 4'h2,
    4'h2, 4'h0, 4'h1, 4'hF, 4'h5, 4'h1, 4'h0, 4'h1, 4'h3, 4'h0};
  localparam logic [1:0] V_KIND [N] = '{
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
    2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0};
  localparam logic V_TAKE [N] = '{
    0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam logic V_ILL [N] = '{
    0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] inst_i = '0;
  logic [31:0] next_word_i = '0;
  logic [3:0]  dst_idx_o, src1_idx_o;
  logic [1:0]  src1_kind_o;
  logic [31:0] rhs_o;
  logic        take_next_o, illegal_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  alu_opnd_gen i_alu_opnd_gen (.*);

  function automatic string req_of(int i);
    case (i)
      0:          return "R4";
      1:          return "R5";
      2, 3:       return "R6";
      4, 5, 6, 7, 8: return "R7";
      9, 10, 11:  return "R8";
      12, 13, 14: return "R9";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, int i);
    check(req, "rhs", rhs_o, V_RHS[i]);
    check("R3", "dst", 32'(dst_idx_o), 32'(V_DST[i]));
    check("R3", "src1", 32'(src1_idx_o), 32'(V_SRC[i]));
    check(req, "kind", 32'(src1_kind_o), 32'(V_KIND[i]));
    check(req, "take", 32'(take_next_o), 32'(V_TAKE[i]));
    check(req, "illegal", 32'(illegal_o), 32'(V_ILL[i]));
  endtask

  task automatic check_zero(string req);
    check(req, "rhs", rhs_o, 32'h0);
    check(req, "dst", 32'(dst_idx_o), 32'h0);
    check(req, "src1", 32'(src1_idx_o), 32'h0);
    check(req, "flags", {28'h0, src1_kind_o, take_next_o, illegal_o}, 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs at zero even with a live instruction
    inst_i = V_INST[9];
    next_word_i = V_NEXT[9];
    repeat (3) @(negedge clk_i);
    check_zero("R1");
    rst_ni = 1'b1;

    // Vector table, one instruction per cycle
    for (int i = 0; i < N; i++) begin
      @(negedge clk_i);
      inst_i = V_INST[i];
      next_word_i = V_NEXT[i];
      @(negedge clk_i);
      check_all(req_of(i), i);
    end

    // R2: a change between edges leaves outputs alone, the next edge takes it
    @(negedge clk_i);
    inst_i = V_INST[1];
    next_word_i = '0;
    @(negedge clk_i);
    inst_i = V_INST[0];
    #1;
    check("R2", "rhs held", rhs_o, V_RHS[1]);
    @(negedge clk_i);
    check("R2", "rhs updated", rhs_o, V_RHS[0]);

    // R8: escape word ignored when the value is not the escape code
    inst_i = 32'h4230278F;
    next_word_i = 32'hFFFFFFFF;
    @(negedge clk_i);
    check("R8", "no escape rhs", rhs_o, 32'h0000007F);
    check("R8", "no escape take", 32'(take_next_o), 32'h0);

    // R1: asynchronous reset in mid-run clears at once
    inst_i = V_INST[9];
    next_word_i = V_NEXT[9];
    @(negedge clk_i);
    check("R8", "escape before reset", 32'(take_next_o), 32'h1);
    #1 rst_ni = 1'b0;
    #0.5;
    check_zero("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8", "after reset", rhs_o, V_RHS[9]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule